// File: doc/BRIEF.md
# Page-Aligned Flash Program Sequencer

This block turns one program request, a start address and a byte count, into the serial-flash command traffic needed to store a byte stream without letting any single program command run past a flash page boundary. Data arrives on a ready/valid byte stream. Commands leave as bytes on a byte-level serial master interface, where a chip-select level marks each command frame.

The first chunk of a request runs from the start address only to the end of its page. Every later chunk is a full page, except the final one, which carries whatever remains. Before each chunk the block polls the status register until the busy flag reads clear, then sends a write-enable frame, and only then sends the program frame. The input stream is held off for the whole of the poll and write-enable phases.

When the request finishes, the block pulses a completion strobe with the number of data bytes programmed. Requests that would run past the end of the device are refused without any serial traffic. Requests of zero length complete at once.

Top module: `page_prog_splitter`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `spi_cs`, `done` and `wr_ready` are 0.
- R2: When (start address mod PAGE_BYTES) + length <= PAGE_BYTES, exactly one program frame is sent, and it carries all of the bytes.
- R3: Otherwise the first program frame carries PAGE_BYTES - (start mod PAGE_BYTES) bytes. Each later frame carries min(PAGE_BYTES, bytes remaining) at the start address plus the bytes already sent. No frame crosses a page boundary.
- R4: A program frame is a single chip-select frame: byte 0x02, then ADDR_BYTES address bytes with the most significant first, then the data bytes in stream order.
- R5: Before every program frame the block sends one or more status frames. Each status frame is the two bytes 0x05 and 0x00, and the status value is the byte returned for the second of them. Status frames repeat while bit 0 of that value is 1. One write-enable frame, the single byte 0x06, follows the first status value with bit 0 equal to 0. Other status bits are ignored.
- R6: A request with start + length > DEV_BYTES completes with `done_err`=1 and `done_count`=0. It sends no serial bytes and consumes no stream bytes.
- R7: A zero-length request completes with `done_err`=0 and `done_count`=0. It sends no serial bytes.
- R8: Stream bytes are accepted only during the data phase of a program frame, one serial byte per stream byte. Throughout the status and write-enable phases the stream is held off.
- R9: On success, `done` is a single-cycle pulse with `done_err`=0 and `done_count` equal to the number of data bytes sent, which excludes opcode and address bytes. `req_ready` is 1 again in the following cycle.
- R10: A frame's chip select falls only after one returned byte (`spi_rx_valid`) has arrived for every byte sent in that frame. Chip select stays low for at least one cycle between frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Program request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 8*ADDR_BYTES | Start address in flash |
| req_len | input | LEN_W | Number of bytes to program |
| wr_valid | input | 1 | Stream byte offered |
| wr_ready | output | 1 | Stream byte taken this cycle |
| wr_data | input | 8 | Stream byte |
| done | output | 1 | Single-cycle completion strobe |
| done_err | output | 1 | Request was refused as out of range |
| done_count | output | LEN_W | Data bytes programmed |
| spi_cs | output | 1 | Frame active (chip select asserted) |
| spi_tx_valid | output | 1 | Serial byte offered to the master |
| spi_tx_ready | input | 1 | Master takes the offered byte |
| spi_tx_data | output | 8 | Serial byte to send |
| spi_rx_valid | input | 1 | Master returns the byte shifted in for one sent byte |
| spi_rx_data | input | 8 | Returned byte |

## Verification
Two events can land in the same cycle. The stream may offer a byte while a status reply is still on its way back. The master may also return the final byte of a frame in the same cycle that the frame would otherwise close. The bench provokes both by driving `wr_valid` with no regard to the block's phase and by delaying returned bytes at random, with random busy counts before each chunk. Each frame is then judged from the recorded serial bytes: no stream byte may appear outside a program data phase, and no chip-select fall may arrive while a returned byte is still owed.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_OP, S_ADDR, S_DATA, S_DUMMY, S_DRAIN, S_GAP, S_DONE
  } pps_state_e;

  typedef enum logic [1:0] {
    K_POLL, K_WREN, K_PROG
  } pps_kind_e;

  localparam logic [7:0] CMD_STATUS = 8'h05;
  localparam logic [7:0] CMD_WREN   = 8'h06;
  localparam logic [7:0] CMD_PROG   = 8'h02;

  // bytes left from addr to the end of its page (page is a power of two)
  function automatic logic [31:0] page_room(logic [31:0] addr, logic [31:0] page);
    return page - (addr & (page - 32'd1));
  endfunction

  // size of the next chunk: stop at page end or at the end of the data
  function automatic logic [31:0] chunk_bytes(logic [31:0] addr, logic [31:0] rem,
                                              logic [31:0] page);
    logic [31:0] room;
    room = page_room(addr, page);
    return (room < rem) ? room : rem;
  endfunction

  // true when the last byte would lie past the device end
  function automatic logic past_end(logic [31:0] addr, logic [31:0] len,
                                    logic [31:0] dev);
    return ({1'b0, addr} + {1'b0, len}) > {1'b0, dev};
  endfunction

endpackage

// File: rtl/pps_chunk_track.sv
module pps_chunk_track
  import pps_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 17,
  parameter int CW         = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              start_chunk,
  input  logic              byte_fire,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  sent_count,
  output logic              last_in_chunk,
  output logic              all_sent
);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(PAGE_BYTES - 1);

  logic [LEN_W-1:0] rem_len;
  logic [CW-1:0]    chunk_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr   <= '0;
      rem_len    <= '0;
      sent_count <= '0;
      chunk_left <= '0;
    end else if (load) begin
      cur_addr   <= load_addr;
      rem_len    <= load_len;
      sent_count <= '0;
      chunk_left <= '0;
    end else if (start_chunk) begin
      chunk_left <= CW'(chunk_bytes(32'(cur_addr), 32'(rem_len), 32'(PAGE_BYTES)));
    end else if (byte_fire) begin
      cur_addr   <= cur_addr + 1'b1;
      rem_len    <= rem_len - 1'b1;
      sent_count <= sent_count + 1'b1;
      chunk_left <= chunk_left - 1'b1;
    end
  end

  assign last_in_chunk = (chunk_left == CW'(1));
  assign all_sent      = (rem_len == '0);

  // R3: a byte that does not close its chunk never sits on the last page offset
  p_no_cross_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_fire && !last_in_chunk |-> (cur_addr & OFS_MASK) != OFS_MASK);

  // R9: no byte is sent once the request is exhausted
  p_no_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_fire |-> !all_sent);

endmodule

// File: rtl/pps_frame_mon.sv
module pps_frame_mon #(
  parameter int FW = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       tx_fire,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       drained,
  output logic       busy
);
  logic [FW-1:0] tx_cnt;
  logic [FW-1:0] rx_cnt;
  logic [7:0]    status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_cnt   <= '0;
      rx_cnt   <= '0;
      status_q <= '0;
    end else if (!cs) begin
      tx_cnt <= '0;
      rx_cnt <= '0;
    end else begin
      if (tx_fire) tx_cnt <= tx_cnt + 1'b1;
      if (rx_valid) begin
        rx_cnt <= rx_cnt + 1'b1;
        if (rx_cnt == FW'(1)) status_q <= rx_data;
      end
    end
  end

  assign drained = (tx_cnt == rx_cnt);
  assign busy    = status_q[0];

  // R10: the master never returns more bytes than were sent in the frame
  p_rx_le_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs |-> rx_cnt <= tx_cnt);

endmodule

// File: rtl/page_prog_splitter.sv
module page_prog_splitter
  import pps_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int ADDR_BYTES = 3,
  parameter int DEV_BYTES  = 65536,
  parameter int LEN_W      = 17
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [8*ADDR_BYTES-1:0] req_addr,
  input  logic [LEN_W-1:0]        req_len,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [7:0]              wr_data,
  output logic                    done,
  output logic                    done_err,
  output logic [LEN_W-1:0]        done_count,
  output logic                    spi_cs,
  output logic                    spi_tx_valid,
  input  logic                    spi_tx_ready,
  output logic [7:0]              spi_tx_data,
  input  logic                    spi_rx_valid,
  input  logic [7:0]              spi_rx_data
);
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int CW     = $clog2(PAGE_BYTES) + 1;
  localparam int FW     = $clog2(PAGE_BYTES + ADDR_BYTES + 2) + 1;
  localparam int ABW    = $clog2(ADDR_BYTES) + 1;

  pps_state_e     state;
  pps_kind_e      kind;
  logic [ABW-1:0] ab_idx;
  logic           err_q;

  // named internal events
  logic              req_take, req_empty, req_out_of_range;
  logic              tx_fire, byte_fire, start_chunk;
  logic              drained, busy, last_in_chunk, all_sent;
  logic [ADDR_W-1:0] cur_addr;
  logic [7:0]        addr_byte;

  assign req_ready        = (state == S_IDLE);
  assign req_take         = req_valid && req_ready;
  assign req_empty        = (req_len == '0);
  assign req_out_of_range = past_end(32'(req_addr), 32'(req_len), 32'(DEV_BYTES));
  assign tx_fire          = spi_tx_valid && spi_tx_ready;
  assign byte_fire        = (state == S_DATA) && tx_fire;
  assign start_chunk      = (state == S_GAP) && (kind == K_WREN);

  pps_chunk_track #(
    .PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CW(CW)
  ) u_track (
    .clk(clk), .rst_n(rst_n),
    .load(req_take), .load_addr(req_addr), .load_len(req_len),
    .start_chunk(start_chunk), .byte_fire(byte_fire),
    .cur_addr(cur_addr), .sent_count(done_count),
    .last_in_chunk(last_in_chunk), .all_sent(all_sent)
  );

  pps_frame_mon #(.FW(FW)) u_mon (
    .clk(clk), .rst_n(rst_n), .cs(spi_cs), .tx_fire(tx_fire),
    .rx_valid(spi_rx_valid), .rx_data(spi_rx_data),
    .drained(drained), .busy(busy)
  );

  always_comb begin
    addr_byte = '0;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (ab_idx == ABW'(i)) addr_byte = cur_addr[8*(ADDR_BYTES-1-i) +: 8];
    end
  end

  always_comb begin
    spi_tx_valid = 1'b0;
    spi_tx_data  = 8'h00;
    unique case (state)
      S_OP: begin
        spi_tx_valid = 1'b1;
        unique case (kind)
          K_POLL:  spi_tx_data = CMD_STATUS;
          K_WREN:  spi_tx_data = CMD_WREN;
          default: spi_tx_data = CMD_PROG;
        endcase
      end
      S_ADDR:  begin spi_tx_valid = 1'b1; spi_tx_data = addr_byte; end
      S_DUMMY: begin spi_tx_valid = 1'b1; spi_tx_data = 8'h00; end
      S_DATA:  begin spi_tx_valid = wr_valid; spi_tx_data = wr_data; end
      default: ;
    endcase
  end

  assign spi_cs   = !(state inside {S_IDLE, S_GAP, S_DONE});
  assign wr_ready = (state == S_DATA) && spi_tx_ready;
  assign done     = (state == S_DONE);
  assign done_err = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      kind   <= K_POLL;
      ab_idx <= '0;
      err_q  <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (req_take) begin
          err_q <= 1'b0;
          kind  <= K_POLL;
          if (req_empty) state <= S_DONE;
          else if (req_out_of_range) begin
            err_q <= 1'b1;
            state <= S_DONE;
          end else state <= S_OP;
        end
        S_OP: if (tx_fire) begin
          unique case (kind)
            K_POLL:  state <= S_DUMMY;
            K_WREN:  state <= S_DRAIN;
            default: begin ab_idx <= '0; state <= S_ADDR; end
          endcase
        end
        S_ADDR: if (tx_fire) begin
          if (ab_idx == ABW'(ADDR_BYTES - 1)) state <= S_DATA;
          else ab_idx <= ab_idx + 1'b1;
        end
        S_DUMMY: if (tx_fire) state <= S_DRAIN;
        S_DATA:  if (byte_fire && last_in_chunk) state <= S_DRAIN;
        S_DRAIN: if (drained) state <= S_GAP;
        S_GAP: begin
          state <= S_OP;
          unique case (kind)
            K_POLL: kind <= busy ? K_POLL : K_WREN;
            K_WREN: kind <= K_PROG;
            default: begin
              if (all_sent) state <= S_DONE;
              else kind <= K_POLL;
            end
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6: an out-of-range request ends at once with the error flag
  p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_take && !req_empty && req_out_of_range |=> done && done_err);

  // R8: stream bytes move only inside a frame, onto the serial side
  p_wr_framed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |-> spi_cs && spi_tx_valid);

  // R9: completion is a single pulse followed by idle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

  // R10: a frame closes only once every returned byte has arrived
  p_drained_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs) |-> $past(drained));

endmodule

// File: tb/page_prog_splitter_bench.sv
module page_prog_splitter_bench;
  localparam int PAGE = 256;
  localparam int AB   = 3;
  localparam int DEV  = 65536;
  localparam int LW   = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [8*AB-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [7:0] wr_data = '0;
  logic done, done_err;
  logic [LW-1:0] done_count;
  logic spi_cs, spi_tx_valid, spi_tx_ready;
  logic [7:0] spi_tx_data;
  logic spi_rx_valid = 1'b0;
  logic [7:0] spi_rx_data = '0;

  page_prog_splitter #(.PAGE_BYTES(PAGE), .ADDR_BYTES(AB), .DEV_BYTES(DEV), .LEN_W(LW))
  u_page_prog_splitter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .done(done), .done_err(done_err), .done_count(done_count),
    .spi_cs(spi_cs), .spi_tx_valid(spi_tx_valid), .spi_tx_ready(spi_tx_ready),
    .spi_tx_data(spi_tx_data), .spi_rx_valid(spi_rx_valid), .spi_rx_data(spi_rx_data)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0] fb[$];
  int fl[$];
  int busy_q[$];
  logic [7:0] rx_q[$];
  int busy_left = 0;
  int frame_start = 0;
  logic cs_prev = 1'b0;
  int s_idx = 0;
  int s_len = 0;
  logic [7:0] sbase = '0;
  bit restart = 0;
  bit w_acc = 0;
  int r8_bad = 0;
  int r10_bad = 0;
  bit done_seen = 0;
  bit req_taken = 0;
  logic got_err;
  int got_count;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // environment: serial master model, stream source, monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (restart) begin wr_valid = 1'b0; restart = 0; w_acc = 0; end
      if (w_acc) begin wr_valid = 1'b0; w_acc = 0; end
      if (!wr_valid && s_idx < s_len && ($urandom % 4) != 0) begin
        wr_valid = 1'b1;
        wr_data  = 8'(int'(sbase) + s_idx);
      end
      spi_tx_ready = ($urandom % 4) != 0;
      if (rx_q.size() > 0 && ($urandom % 3) != 0) begin
        spi_rx_valid = 1'b1;
        spi_rx_data  = rx_q.pop_front();
      end else spi_rx_valid = 1'b0;
      #8;
      if (spi_cs && !cs_prev) frame_start = fb.size();
      if (!spi_cs && cs_prev) begin
        fl.push_back(fb.size() - frame_start);
        if (rx_q.size() != 0 || spi_rx_valid) r10_bad++;
        if (fb.size() > frame_start && fb[frame_start] == 8'h02) begin
          busy_left = $urandom % 3;
          busy_q.push_back(busy_left);
        end
      end
      if (spi_tx_valid && spi_tx_ready) begin
        int pos;
        if (!spi_cs) r10_bad++;
        fb.push_back(spi_tx_data);
        pos = fb.size() - 1 - frame_start;
        if (pos == 1 && fb[frame_start] == 8'h05) begin
          if (busy_left > 0) begin rx_q.push_back(8'h03); busy_left--; end
          else rx_q.push_back(8'hFC);
        end else rx_q.push_back(8'h5A);
        if (wr_valid && wr_ready) begin
          if (fb[frame_start] != 8'h02 || pos < 1 + AB) r8_bad++;
        end
      end
      if (wr_valid && wr_ready) begin
        if (!(spi_tx_valid && spi_tx_ready)) r8_bad++;
        s_idx++;
        w_acc = 1;
      end
      if (done) begin
        done_seen = 1;
        got_err   = done_err;
        got_count = int'(done_count);
      end
      if (req_valid && req_ready) req_taken = 1;
      cs_prev = spi_cs;
    end
  end

  task automatic run_req(input int addr, input int len);
    int pos, fi, off, ci, n, a, b3, b4, b5, nchunks;
    bit rej;
    @(negedge clk);
    fb.delete(); fl.delete(); busy_q.delete();
    busy_left = $urandom % 3;
    busy_q.push_back(busy_left);
    s_idx = 0; s_len = len; sbase = 8'($urandom); restart = 1;
    r8_bad = 0; r10_bad = 0; done_seen = 0; req_taken = 0;
    req_addr = (8*AB)'(addr); req_len = LW'(len); req_valid = 1'b1;
    do @(negedge clk); while (!req_taken);
    req_valid = 1'b0;
    while (!done_seen) @(negedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready after done", int'(req_ready), 1);
    rej = (addr + len > DEV);
    if (len == 0) begin
      chk(got_err == 1'b0 && got_count == 0, "R7", "zero-length count", got_count, 0);
      chk(fl.size() == 0 && fb.size() == 0, "R7", "zero-length serial bytes", fb.size(), 0);
    end else if (rej) begin
      chk(got_err == 1'b1, "R6", "reject flag", int'(got_err), 1);
      chk(got_count == 0 && fb.size() == 0, "R6", "reject serial bytes", fb.size(), 0);
      chk(s_idx == 0, "R6", "reject stream consumed", s_idx, 0);
    end else begin
      pos = 0; fi = 0; off = 0; ci = 0; b3 = 0; b4 = 0; b5 = 0; nchunks = 0;
      while (pos < len) begin
        a = addr + pos;
        n = PAGE - (a % PAGE);
        if (n > len - pos) n = len - pos;
        for (int p = 0; p <= (ci < busy_q.size() ? busy_q[ci] : 0); p++) begin
          if (fi >= fl.size() || fl[fi] != 2 || fb[off] != 8'h05 || fb[off+1] != 8'h00) b5++;
          if (fi < fl.size()) begin off += fl[fi]; fi++; end
        end
        if (fi >= fl.size() || fl[fi] != 1 || fb[off] != 8'h06) b5++;
        if (fi < fl.size()) begin off += fl[fi]; fi++; end
        if (fi >= fl.size()) b3++;
        else begin
          if (fl[fi] != 1 + AB + n) b3++;
          else begin
            if (fb[off] != 8'h02) b4++;
            for (int b = 0; b < AB; b++)
              if (fb[off+1+b] != 8'(a >> (8*(AB-1-b)))) b4++;
            for (int k = 0; k < n; k++)
              if (fb[off+1+AB+k] != 8'(int'(sbase) + pos + k)) b4++;
          end
          off += fl[fi]; fi++;
        end
        pos += n; ci++; nchunks++;
      end
      if (fi != fl.size()) b3++;
      if (nchunks == 1) chk(b3 == 0, "R2", "single in-page frame", b3, 0);
      else              chk(b3 == 0, "R3", "page split sizes", b3, 0);
      chk(b4 == 0, "R4", "program frame layout", b4, 0);
      chk(b5 == 0, "R5", "busy poll and write-enable", b5, 0);
      chk(got_err == 1'b0 && got_count == len, "R9", "programmed count", got_count, len);
      chk(s_idx == len && r8_bad == 0, "R8", "stream gating", r8_bad, 0);
    end
    chk(r10_bad == 0, "R10", "frame close and gap", r10_bad, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && spi_cs == 1'b0 && done == 1'b0 && wr_ready == 1'b0,
        "R1", "reset outputs", int'({req_ready, spi_cs, done, wr_ready}), 8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && spi_cs == 1'b0 && done == 1'b0,
        "R1", "first cycle after reset", int'({req_ready, spi_cs, done}), 4);
    run_req(100, 0);              // R7
    run_req(0, PAGE);             // R2 exact page
    run_req(PAGE - 1, 2);         // R3 one byte each side
    run_req(3 * PAGE, 3 * PAGE);  // R3 aligned full pages
    run_req(5 * PAGE + 17, 40);   // R2 inside page
    run_req(DEV - 300, 300);      // ends exactly at device end
    run_req(DEV - 300, 301);      // R6 one past end
    run_req(DEV, 1);              // R6
    for (int t = 0; t < 30; t++) begin
      int pg, ofs, ln;
      pg = $urandom % (DEV / PAGE);
      case ($urandom % 4)
        0: ofs = 0;
        1: ofs = PAGE - 1;
        2: ofs = PAGE - 3;
        default: ofs = $urandom % PAGE;
      endcase
      ln = $urandom % (3 * PAGE + 6);
      if (t % 10 == 9) pg = DEV / PAGE - 1;
      run_req(pg * PAGE + ofs, ln);
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule